// File: doc/BRIEF.md
# Enable-Framed Three-Wire Serial Byte Loader

This block receives write-only configuration bytes over three wires: a serial clock, a serial data line and an active-low frame enable. All three pins are asynchronous to the fast system clock. Each pin passes through a two-flop synchronizer, and all pin edges are found by comparing successive synchronized samples. While the enable is low, every rising serial-clock edge shifts one data bit into a holding register, most significant bit first. A saturating bit counter stops accepting bits once a full word is held. When the enable returns high, the block hands exactly one word to the register bank, as a one-cycle strobe with the byte. Frames that end too early, and frames started before the enable has been high long enough, produce a one-cycle error pulse and no strobe.

The controller is a four-state machine. IDLE: the enable is high and the guard time has passed. FRAME: the enable is low and bits are collected. GAP: the enable is high and the guard time is being counted. BAD: the enable fell too soon, so the frame is being ignored. The transitions are IDLE to FRAME on an enable fall. FRAME to GAP on an enable rise, committing or aborting. GAP to IDLE when the guard count reaches `MIN_GAP`. GAP to FRAME on an enable fall after the guard time. GAP to BAD on an enable fall before the guard time. BAD to GAP on an enable rise, aborting. After reset the machine is in IDLE, so the first frame needs no guard time.

Top module: `wr3_frame_loader`

## Requirements
- R1: During and right after reset, `commit_stb` and `abort_err` are 0 and `commit_byte` is 0.
- R2: Bits are taken on rising edges of `ser_clk` while `ser_en_n` is low. The first bit taken becomes bit 7 of the committed byte and the eighth becomes bit 0.
- R3: When `ser_en_n` rises after at least 8 bits were taken, `commit_stb` is 1 for exactly one cycle. That cycle is the third system clock after the rise is presented at the pin. `commit_byte` carries the word in that same cycle.
- R4: When more than 8 rising `ser_clk` edges occur in one frame, only the first 8 bits are committed.
- R5: When `ser_en_n` rises after fewer than 8 bits (zero included), no strobe is given. `abort_err` is 1 for one cycle, with the same timing as R3, and `commit_byte` keeps its previous value.
- R6: The guard time is measured in system-clock cycles. If `ser_en_n` has been high for fewer than `MIN_GAP` cycles before it falls, the frame is discarded and reported per R5 when it ends, whatever its length. A frame whose enable was high for `MIN_GAP` cycles or more is accepted.
- R7: A `ser_clk` rise seen in the same synchronized sample as an enable fall or an enable rise is not taken as a bit.
- R8: `commit_stb` and `abort_err` are never 1 together, and `commit_byte` changes only in a cycle where `commit_stb` is 1.
- R9: Rising `ser_clk` edges while `ser_en_n` is high have no effect on the next frame's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on `ser_clk` rising edges |
| ser_en_n | input | 1 | Active-low frame enable, asynchronous |
| commit_stb | output | 1 | One-cycle pulse when a byte is handed on |
| commit_byte | output | DATA_W | Last committed byte |
| abort_err | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
Two events can land in the same synchronized sample: the serial-clock edge that carries a bit, and the enable edge that opens or closes a frame. The bench drives `ser_clk` high on the very same system-clock cycle as `ser_en_n` falls, and in another case as `ser_en_n` rises. It judges the result by the byte length that then reaches the ports. An 8-edge frame whose final or first edge coincides with the enable edge must abort. A 9-edge frame in the same situation must commit the 8 bits that remain. A second pairing is an enable fall arriving on the exact guard-time boundary. The bench steps the gap across `MIN_GAP - 1` and `MIN_GAP` and expects a discard and then an accept.

// File: rtl/wr3_pkg.sv
package wr3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2,
        ST_BAD   = 2'd3
    } wr3_state_e;

endpackage

// File: rtl/wr3_sync.sv
module wr3_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/wr3_shifter.sv
module wr3_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              take,
    input  logic              s_dat,
    output logic              full,
    output logic [DATA_W-1:0] word
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;

    assign full = (bit_cnt == CNT_W'(DATA_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (clr) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (shift_en && !full) begin
            shreg   <= {shreg[DATA_W-2:0], s_dat};
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (take) begin
            word <= shreg;
        end
    end

endmodule

// File: rtl/wr3_ctrl.sv
module wr3_ctrl
    import wr3_pkg::*;
#(
    parameter int MIN_GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_clk,
    input  logic s_en_n,
    input  logic full,
    output logic clr,
    output logic shift_en,
    output logic take,
    output logic commit_stb,
    output logic abort_err
);

    localparam int GAP_W = $clog2(MIN_GAP + 1);

    wr3_state_e       state, state_nxt;
    logic [GAP_W-1:0] gap_cnt;
    logic             p_clk, p_en_n;
    logic             clk_rise, en_fall, en_rise, gap_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_clk  <= 1'b0;
            p_en_n <= 1'b1;
        end else begin
            p_clk  <= s_clk;
            p_en_n <= s_en_n;
        end
    end

    assign clk_rise = s_clk & ~p_clk;
    assign en_fall  = ~s_en_n & p_en_n;
    assign en_rise  = s_en_n & ~p_en_n;
    assign gap_ok   = (gap_cnt >= GAP_W'(MIN_GAP));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (en_fall) state_nxt = ST_FRAME;
            ST_FRAME: if (en_rise) state_nxt = ST_GAP;
            ST_GAP: begin
                if (en_fall)     state_nxt = gap_ok ? ST_FRAME : ST_BAD;
                else if (gap_ok) state_nxt = ST_IDLE;
            end
            ST_BAD:   if (en_rise) state_nxt = ST_GAP;
        endcase
    end

    // state register with the guard-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt == ST_GAP && state != ST_GAP) begin
                gap_cnt <= GAP_W'(1);
            end else if (state == ST_GAP && !gap_ok) begin
                gap_cnt <= gap_cnt + GAP_W'(1);
            end
        end
    end

    assign clr      = (state_nxt == ST_FRAME) && (state != ST_FRAME);
    assign shift_en = (state == ST_FRAME) && clk_rise && !s_en_n;
    assign take     = (state == ST_FRAME) && en_rise && full;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_stb <= 1'b0;
            abort_err  <= 1'b0;
        end else begin
            commit_stb <= take;
            abort_err  <= en_rise && (((state == ST_FRAME) && !full) || (state == ST_BAD));
        end
    end

endmodule

// File: rtl/wr3_frame_loader.sv
module wr3_frame_loader #(
    parameter int DATA_W  = 8,
    parameter int MIN_GAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en_n,
    output logic              commit_stb,
    output logic [DATA_W-1:0] commit_byte,
    output logic              abort_err
);

    localparam int SYNC_STAGES = 2;

    logic [2:0] pins_s;
    logic       clr, shift_en, take, full;

    wr3_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_en_n, ser_dat, ser_clk}),
        .q     (pins_s)
    );

    wr3_ctrl #(
        .MIN_GAP (MIN_GAP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_clk      (pins_s[0]),
        .s_en_n     (pins_s[2]),
        .full       (full),
        .clr        (clr),
        .shift_en   (shift_en),
        .take       (take),
        .commit_stb (commit_stb),
        .abort_err  (abort_err)
    );

    wr3_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (shift_en),
        .take     (take),
        .s_dat    (pins_s[1]),
        .full     (full),
        .word     (commit_byte)
    );

endmodule

// File: rtl/wr3_frame_loader_chk.sv
module wr3_frame_loader_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_en_n,
    input logic              commit_stb,
    input logic [DATA_W-1:0] commit_byte,
    input logic              abort_err
);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_stb && abort_err));

    a_r8_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |-> $stable(commit_byte));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |=> !abort_err);

    a_r3_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> ($past(ser_en_n, 3) && !$past(ser_en_n, 4)));

    a_r5_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> ($past(ser_en_n, 3) && !$past(ser_en_n, 4)));

endmodule

bind wr3_frame_loader wr3_frame_loader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_en_n    (ser_en_n),
    .commit_stb  (commit_stb),
    .commit_byte (commit_byte),
    .abort_err   (abort_err)
);

// File: tb/test_wr3_frame_loader.sv
`timescale 1ns/1ps
module test_wr3_frame_loader;

    localparam int MIN_GAP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       commit_stb;
    logic [7:0] commit_byte;
    logic       abort_err;

    int total = 0;
    int bad = 0;
    int prev_gap = 1000;
    logic [7:0] last_byte = 8'h00;

    always #10 clk = ~clk;

    wr3_frame_loader #(.DATA_W(8), .MIN_GAP(MIN_GAP)) i_wr3_frame_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_dat     (ser_dat),
        .ser_en_n    (ser_en_n),
        .commit_stb  (commit_stb),
        .commit_byte (commit_byte),
        .abort_err   (abort_err)
    );

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk1(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one frame, then 'gap' high cycles of observation
    task automatic do_frame(input logic [15:0] pat, input int nbits, input int gap,
                            input bit cs, input bit ce, input bit noise, input string tag);
        int n_stb = 0, n_err = 0, stb_c = 0, err_c = 0, eff;
        bit accept, want_commit, ok;
        logic [7:0] exp_byte, byte_now;
        accept      = (prev_gap >= MIN_GAP);
        eff         = nbits - int'(cs) - int'(ce);
        want_commit = accept && (eff >= 8);
        exp_byte    = pat[15 - int'(cs) -: 8];

        ser_en_n = 1'b0;
        if (cs) begin
            ser_dat = pat[15];
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(2);
        end else begin
            wait_n(3);
        end
        for (int i = int'(cs); i < nbits; i++) begin
            ser_dat = pat[15 - i];
            wait_n(2);
            if (ce && i == nbits - 1) begin
                wait_n(3);
                ser_clk  = 1'b1;
                ser_en_n = 1'b1;
            end else begin
                ser_clk = 1'b1;
                wait_n(4);
                ser_clk = 1'b0;
                wait_n(2);
            end
        end
        if (!ce) begin
            wait_n(3);
            ser_en_n = 1'b1;
        end
        for (int c = 1; c <= gap; c++) begin
            @(negedge clk);
            if (commit_stb) begin n_stb++; stb_c = c; end
            if (abort_err)  begin n_err++; err_c = c; end
            if (noise && c == 1) begin ser_clk = 1'b1; ser_dat = ~ser_dat; end
            if (noise && c == 3) ser_clk = 1'b0;
            if (c == gap) ser_clk = 1'b0;
        end
        byte_now = commit_byte;

        total++;
        if (want_commit) begin
            ok = (n_stb == 1) && (stb_c == 3) && (n_err == 0) && (byte_now == exp_byte);
            last_byte = exp_byte;
        end else begin
            ok = (n_err == 1) && (err_c == 3) && (n_stb == 0) && (byte_now == last_byte);
        end
        if (!ok) begin
            bad++;
            $display("FAIL %s: stb=%0d@%0d err=%0d@%0d byte=%02h, expected %s@3 byte=%02h",
                     tag, n_stb, stb_c, n_err, err_c, byte_now,
                     want_commit ? "commit" : "abort", want_commit ? exp_byte : last_byte);
        end
        prev_gap = gap;
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(5);
        chk1("R1 stb in reset", {7'd0, commit_stb}, 8'h00);
        chk1("R1 err in reset", {7'd0, abort_err}, 8'h00);
        rst_n = 1'b1;
        wait_n(2);
        chk1("R1 byte after reset", commit_byte, 8'h00);
        chk1("R1 stb after reset", {7'd0, commit_stb}, 8'h00);
        wait_n(10);

        // R2, R3: every byte value, plain 8-bit frames
        for (int v = 0; v < 256; v++)
            do_frame({8'(v), 8'h00}, 8, 6, 1'b0, 1'b0, 1'b0, "R2 R3 byte sweep");

        // R4: over-long frames keep the first 8 bits
        for (int n = 9; n <= 16; n++)
            do_frame(16'hA53C ^ 16'(n * 16'h1111), n, 6, 1'b0, 1'b0, 1'b0, "R4 long frame");

        // R5: short frames, zero bits included
        for (int n = 0; n <= 7; n++)
            do_frame(16'h6E91, n, 6, 1'b0, 1'b0, 1'b0, "R5 short frame");

        // R6: guard time boundary
        do_frame(16'h3C00, 8, MIN_GAP - 1, 1'b0, 1'b0, 1'b0, "R6 frame before short gap");
        do_frame(16'hC300, 8, MIN_GAP - 1, 1'b0, 1'b0, 1'b0, "R6 short gap discards");
        do_frame(16'h5A00, 12, MIN_GAP, 1'b0, 1'b0, 1'b0, "R6 short gap discards long");
        do_frame(16'h9900, 8, 6, 1'b0, 1'b0, 1'b0, "R6 exact gap accepted");
        do_frame(16'h7700, 8, 6, 1'b0, 1'b0, 1'b0, "R6 long gap accepted");

        // R7: clock rise coinciding with enable edges
        do_frame(16'hB6FF, 8, 6, 1'b0, 1'b1, 1'b0, "R7 end-coincident 8 bits");
        do_frame(16'hB640, 9, 6, 1'b0, 1'b1, 1'b0, "R7 end-coincident 9 bits");
        do_frame(16'hE5A0, 9, 6, 1'b1, 1'b0, 1'b0, "R7 start-coincident 9 bits");
        do_frame(16'h1F00, 8, 6, 1'b1, 1'b0, 1'b0, "R7 start-coincident 8 bits");
        do_frame(16'h4280, 10, 6, 1'b1, 1'b1, 1'b0, "R7 both coincident 10 bits");

        // R9: clock activity while enable is high
        do_frame(16'h0F00, 8, 8, 1'b0, 1'b0, 1'b1, "R9 noisy gap");
        do_frame(16'hF000, 8, 8, 1'b0, 1'b0, 1'b1, "R9 after noise");
        do_frame(16'h8100, 8, 6, 1'b0, 1'b0, 1'b0, "R9 after noise");

        // R8: no stray outputs while idle
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            total++;
            if (commit_stb || abort_err || commit_byte !== last_byte) begin
                bad++;
                $display("FAIL R8 idle: stb=%0b err=%0b byte=%02h expected 0 0 %02h",
                         commit_stb, abort_err, commit_byte, last_byte);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule